// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block is the private cache of one processor in a shared-bus multiprocessor. It holds a small direct-mapped array with one data word per line. Every line carries a three-state coherence tag: modified, shared or invalid. Loads and stores from the processor complete locally when the line state allows it. Otherwise the processor is stalled while the controller runs bus transactions. These are a plain read for a load miss, a read-for-ownership for any store that lacks ownership, and a writeback when a dirty victim must be evicted first.

The bus is atomic. An external arbiter grants one transaction at a time, and a granted transaction completes in the cycle of its grant. Memory returns fill data in that same cycle. In parallel, the controller watches the transactions of the other caches on a snoop port. It answers a snooped read or read-for-ownership that hits one of its modified lines by driving the line's data as a flush, so that the requester and memory both pick up the current value. It then demotes or invalidates its own copy.

The processor holds its request until a one-cycle ready pulse. It then issues its next operation. As a result, each processor's accesses reach the bus in program order.

Top module: `msiSnoopCache`

## Requirements
- R1: After reset every line is invalid, and `cpuReady`, `busReq` and `snoopFlush` are low.
- R2: A load that misses requests bus command 1 (read) at the load's own address, installs the line as shared whether or not another cache holds it, and returns the fill data.
- R3: A store to a line that is absent or invalid requests bus command 2 (read-for-ownership) and leaves the line modified, holding the store data.
- R4: A store that hits a shared line still requests command 2 before completing, and the line becomes modified.
- R5: A load or store hitting a modified line, and a load hitting a shared line, make no bus request; `cpuReady` rises in the cycle after the request is first seen.
- R6: A snooped read (`snoopExcl`=0) that hits a modified line asserts `snoopFlush` with the line's data on `snoopData` in the same cycle, and the line becomes shared.
- R7: A snooped read-for-ownership (`snoopExcl`=1) invalidates a hit line; it asserts `snoopFlush` with the data only if the line was modified.
- R8: A snooped read hitting a shared line gives no flush, and the line stays shared.
- R9: A miss whose victim line is modified first requests command 3 (writeback) with the victim's address and data, and only then the fill. The victim is invalid afterwards. A shared victim is dropped without any writeback.
- R10: In a cycle with `snoopValid` high, a waiting processor access is not accepted; the snoop is served first, and the access is then judged against the updated line state.
- R11: `cpuReady` is a single-cycle pulse, and for loads `cpuRdata` holds the current value of the addressed word while it is high.
- R12: Once raised, `busReq` stays high with unchanged `busCmd` and `busAddr` until `busGrant`, except in a cycle where a snoop changes the victim; with `busReq` low, `busCmd` is 0.
- R13: A snoop whose address tag does not match the stored tag of a valid line gives no flush and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuReq | input | 1 | Processor access request, held until `cpuReady` |
| cpuWrite | input | 1 | 1 for a store, 0 for a load |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Load result, valid with `cpuReady` |
| busReq | output | 1 | Request for the shared bus |
| busCmd | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 writeback |
| busAddr | output | ADDR_W | Address of the requested transaction |
| busWdata | output | DATA_W | Writeback data |
| busGrant | input | 1 | Grant; the transaction completes in this cycle |
| busFillData | input | DATA_W | Fill data returned in the grant cycle |
| snoopValid | input | 1 | Another cache's transaction is on the bus |
| snoopExcl | input | 1 | 1 if the snooped transaction is a read-for-ownership |
| snoopAddr | input | ADDR_W | Address of the snooped transaction |
| snoopFlush | output | 1 | This cache supplies the snooped line's data |
| snoopData | output | DATA_W | Flushed data |

## Verification
A snoop from another cache can arrive in the very cycle in which the processor presents an access to the same line. Both functions want to read and rewrite that line's state. The bench provokes this by driving a snoop together with a fresh request, often on the same address. It then demands three things. The snoop is answered at once with the correct flush decision. No completion appears in that cycle. The access that follows behaves as the post-snoop state dictates: a demoted line turns a store hit into an upgrade, and an invalidated line turns a hit into a miss. A reference model of line states, memory and the latest value written by anyone judges every bus command, writeback word, flush and load result under seeded random traffic.

// File: rtl/msiPkg.sv
package msiPkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RDX  = 2'd2,
    BUS_WB   = 2'd3
  } busCmd_t;

  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_WBACK = 2'd1,
    C_FILL  = 2'd2,
    C_DONE  = 2'd3
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hitUpdate;    // local hit: update data / latch read result
    logic fillUpdate;   // granted fill: install tag, state, data
    logic victimInv;    // granted writeback: victim becomes invalid
    logic snoopDemote;  // snooped read on modified line
    logic snoopInv;     // snooped read-for-ownership on valid line
    logic selVictim;    // bus address/data come from the victim
  } ctrlStrobe_t;

endpackage

// File: rtl/msiCacheData.sv
module msiCacheData
  import msiPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busFillData,
  input  logic [ADDR_W-1:0] snoopAddr,
  output lineState_t        lineState,
  output logic              lineTagHit,
  output lineState_t        snpState,
  output logic [DATA_W-1:0] snpData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0] cIdx, sIdx;
  logic [TAG_W-1:0] cTag, sTag;

  assign cIdx = cpuAddr[IDX_W-1:0];
  assign cTag = cpuAddr[ADDR_W-1:IDX_W];
  assign sIdx = snoopAddr[IDX_W-1:0];
  assign sTag = snoopAddr[ADDR_W-1:IDX_W];

  lineState_t        stateVec [LINES];
  logic [TAG_W-1:0]  tagVec   [LINES];
  logic [DATA_W-1:0] dataVec  [LINES];

  // one register set per line
  for (genvar i = 0; i < LINES; i++) begin : gLine
    lineState_t        stQ;
    logic [TAG_W-1:0]  tagQ;
    logic [DATA_W-1:0] datQ;
    logic              cpuSel, snpSel;

    assign cpuSel = (cIdx == IDX_W'(i));
    assign snpSel = (sIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ <= LINE_I;
      end else begin
        if (strobe.snoopInv && snpSel)         stQ <= LINE_I;
        else if (strobe.snoopDemote && snpSel) stQ <= LINE_S;
        if (strobe.victimInv && cpuSel)        stQ <= LINE_I;
        if (strobe.fillUpdate && cpuSel)       stQ <= cpuWrite ? LINE_M : LINE_S;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagQ <= '0;
        datQ <= '0;
      end else if (strobe.fillUpdate && cpuSel) begin
        tagQ <= cTag;
        datQ <= cpuWrite ? cpuWdata : busFillData;
      end else if (strobe.hitUpdate && cpuSel && cpuWrite) begin
        datQ <= cpuWdata;
      end
    end

    assign stateVec[i] = stQ;
    assign tagVec[i]   = tagQ;
    assign dataVec[i]  = datQ;
  end

  logic [DATA_W-1:0] lineData;
  logic [DATA_W-1:0] rdQ;

  assign lineState  = stateVec[cIdx];
  assign lineData   = dataVec[cIdx];
  assign lineTagHit = (tagVec[cIdx] == cTag) && (stateVec[cIdx] != LINE_I);

  assign snpState = (tagVec[sIdx] == sTag) ? stateVec[sIdx] : LINE_I;
  assign snpData  = dataVec[sIdx];

  assign busAddr  = strobe.selVictim ? {tagVec[cIdx], cIdx} : cpuAddr;
  assign busWdata = strobe.selVictim ? lineData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strobe.fillUpdate) begin
      rdQ <= cpuWrite ? cpuWdata : busFillData;
    end else if (strobe.hitUpdate) begin
      rdQ <= cpuWrite ? cpuWdata : lineData;
    end
  end

  assign rdata = rdQ;

endmodule

// File: rtl/msiCacheCtrl.sv
module msiCacheCtrl
  import msiPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWrite,
  input  logic        busGrant,
  input  logic        snoopValid,
  input  logic        snoopExcl,
  input  lineState_t  lineState,
  input  logic        lineTagHit,
  input  lineState_t  snpState,
  output ctrlStrobe_t strobe,
  output logic        busReq,
  output busCmd_t     busCmd,
  output logic        cpuReady,
  output logic        snoopFlush
);

  ctrlState_t curSt, nxtSt;

  always_ff @(posedge clk) begin
    if (!rstN) curSt <= C_IDLE;
    else       curSt <= nxtSt;
  end

  logic localHit, dirtyVictim;

  assign localHit    = lineTagHit && (lineState == LINE_M || !cpuWrite);
  assign dirtyVictim = !lineTagHit && (lineState == LINE_M);

  always_comb begin
    strobe   = '0;
    busReq   = 1'b0;
    busCmd   = BUS_IDLE;
    cpuReady = 1'b0;
    nxtSt    = curSt;

    // snoop side, served in the cycle it appears
    snoopFlush         = snoopValid && (snpState == LINE_M);
    strobe.snoopDemote = snoopValid && !snoopExcl && (snpState == LINE_M);
    strobe.snoopInv    = snoopValid && snoopExcl && (snpState != LINE_I);

    unique case (curSt)
      C_IDLE: begin
        if (cpuReq && !snoopValid) begin
          if (localHit) begin
            strobe.hitUpdate = 1'b1;
            nxtSt = C_DONE;
          end else if (dirtyVictim) begin
            nxtSt = C_WBACK;
          end else begin
            nxtSt = C_FILL;
          end
        end
      end
      C_WBACK: begin
        if (lineState == LINE_M) begin
          strobe.selVictim = 1'b1;
          busReq = 1'b1;
          busCmd = BUS_WB;
          if (busGrant) begin
            strobe.victimInv = 1'b1;
            nxtSt = C_FILL;
          end
        end else begin
          // a snoop already cleaned the victim
          nxtSt = C_FILL;
        end
      end
      C_FILL: begin
        busReq = 1'b1;
        busCmd = cpuWrite ? BUS_RDX : BUS_RD;
        if (busGrant) begin
          strobe.fillUpdate = 1'b1;
          nxtSt = C_DONE;
        end
      end
      C_DONE: begin
        cpuReady = 1'b1;
        nxtSt = C_IDLE;
      end
      default: nxtSt = C_IDLE;
    endcase
  end

endmodule

// File: rtl/msiSnoopCache.sv
module msiSnoopCache
  import msiPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busGrant,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snoopValid,
  input  logic              snoopExcl,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              snoopFlush,
  output logic [DATA_W-1:0] snoopData
);

  ctrlStrobe_t strobe;
  lineState_t  lineState, snpState;
  logic        lineTagHit;
  busCmd_t     cmdEnum;

  msiCacheCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWrite   (cpuWrite),
    .busGrant   (busGrant),
    .snoopValid (snoopValid),
    .snoopExcl  (snoopExcl),
    .lineState  (lineState),
    .lineTagHit (lineTagHit),
    .snpState   (snpState),
    .strobe     (strobe),
    .busReq     (busReq),
    .busCmd     (cmdEnum),
    .cpuReady   (cpuReady),
    .snoopFlush (snoopFlush)
  );

  msiCacheData #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cpuWrite    (cpuWrite),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .busFillData (busFillData),
    .snoopAddr   (snoopAddr),
    .lineState   (lineState),
    .lineTagHit  (lineTagHit),
    .snpState    (snpState),
    .snpData     (snoopData),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .rdata       (cpuRdata)
  );

  assign busCmd = cmdEnum;

endmodule

// File: rtl/msiCacheChecker.sv
module msiCacheChecker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWrite,
  input logic              cpuReady,
  input logic              busReq,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busGrant,
  input logic              snoopValid,
  input logic              snoopFlush
);

  a_r12_idle_cmd_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> busCmd == 2'd0);

  a_r12_hold_until_grant: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant && !snoopValid) |=> (busReq && $stable(busCmd) && $stable(busAddr)));

  a_r11_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  a_r9_fill_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant && busCmd == 2'd3) |=> (busReq && (busCmd == 2'd1 || busCmd == 2'd2)));

  a_r6_flush_needs_snoop: assert property (@(posedge clk) disable iff (!rstN)
    snoopFlush |-> snoopValid);

  a_r3_store_uses_readx: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && cpuReq && cpuWrite) |-> busCmd != 2'd1);

  a_r2_load_uses_read: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && cpuReq && !cpuWrite) |-> busCmd != 2'd2);

  a_r10_no_ready_on_idle_snoop: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !busReq && !cpuReady && snoopValid) |=> !cpuReady);

endmodule

bind msiSnoopCache msiCacheChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuReq     (cpuReq),
  .cpuWrite   (cpuWrite),
  .cpuReady   (cpuReady),
  .busReq     (busReq),
  .busCmd     (busCmd),
  .busAddr    (busAddr),
  .busGrant   (busGrant),
  .snoopValid (snoopValid),
  .snoopFlush (snoopFlush)
);

// File: tb/tb_msiSnoopCache.sv
module tb_msiSnoopCache;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 16;
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN;
  logic cpuReq, cpuWrite;
  logic [ADDR_W-1:0] cpuAddr;
  logic [DATA_W-1:0] cpuWdata, cpuRdata;
  logic cpuReady;
  logic busReq;
  logic [1:0] busCmd;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata, busFillData;
  logic busGrant;
  logic snoopValid, snoopExcl, snoopFlush;
  logic [ADDR_W-1:0] snoopAddr;
  logic [DATA_W-1:0] snoopData;

  always #(CLK_PERIOD/2) clk = ~clk;

  msiSnoopCache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busGrant(busGrant), .busFillData(busFillData),
    .snoopValid(snoopValid), .snoopExcl(snoopExcl), .snoopAddr(snoopAddr),
    .snoopFlush(snoopFlush), .snoopData(snoopData)
  );

  // reference model: 0 invalid, 1 shared, 2 modified
  int                   mState [LINES];
  logic [ADDR_W-IDX_W-1:0] mTag [LINES];
  logic [DATA_W-1:0]    mData  [LINES];
  logic [DATA_W-1:0]    mem    [WORDS];
  logic [DATA_W-1:0]    golden [WORDS];

  int nChecks = 0;
  int nErrors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit modelPresent(input logic [ADDR_W-1:0] a);
    int idx = int'(a[IDX_W-1:0]);
    return (mState[idx] != 0) && (mTag[idx] == a[ADDR_W-1:IDX_W]);
  endfunction

  // drive a snoop at the current negedge, check the response, update the model
  task automatic driveSnoop(input logic excl, input logic [ADDR_W-1:0] a);
    int idx = int'(a[IDX_W-1:0]);
    bit present;
    bit expFlush;
    string lbl;
    snoopValid = 1'b1;
    snoopExcl  = excl;
    snoopAddr  = a;
    #1;
    present  = modelPresent(a);
    expFlush = present && mState[idx] == 2;
    if (present && mState[idx] == 2) lbl = excl ? "R7" : "R6";
    else if (present)                lbl = excl ? "R7" : "R8";
    else                             lbl = "R13";
    check(snoopFlush == expFlush, lbl, "snoop flush", snoopFlush, expFlush);
    if (expFlush) begin
      check(snoopData == mData[idx], lbl, "flush data", snoopData, mData[idx]);
      mem[a] = mData[idx];
    end
    if (present) begin
      if (excl) mState[idx] = 0;
      else if (mState[idx] == 2) mState[idx] = 1;
    end
    if (excl) begin
      // the other cache writes a new value and pushes it to memory
      golden[a] = DATA_W'($urandom);
      mem[a] = golden[a];
    end
  endtask

  task automatic snoopOnly(input logic excl, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    driveSnoop(excl, a);
    @(negedge clk);
    snoopValid = 1'b0;
  endtask

  task automatic doOp(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                      input bit withSnoop, input logic snExcl, input logic [ADDR_W-1:0] snAddr);
    int idx = int'(a[IDX_W-1:0]);
    logic [ADDR_W-IDX_W-1:0] tg = a[ADDR_W-1:IDX_W];
    bit hit, expWb, expFill, wbSeen, fillSeen, done, holding, sharedHit;
    logic [1:0] expCmd, hCmd;
    logic [ADDR_W-1:0] vAddr, hAddr;
    logic [DATA_W-1:0] vData;
    int cycles, waitLeft;
    string fillLbl;
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd;
    if (withSnoop) driveSnoop(snExcl, snAddr);
    hit       = modelPresent(a) && (mState[idx] == 2 || !wr);
    sharedHit = modelPresent(a) && mState[idx] == 1;
    expWb     = !modelPresent(a) && mState[idx] == 2;
    expFill   = !hit;
    expCmd    = wr ? 2'd2 : 2'd1;
    fillLbl   = wr ? (sharedHit ? "R4" : "R3") : "R2";
    vAddr     = {mTag[idx], a[IDX_W-1:0]};
    vData     = mData[idx];
    wbSeen = 0; fillSeen = 0; done = 0; holding = 0; cycles = 0; waitLeft = 0;
    hCmd = '0; hAddr = '0;
    while (!done && cycles < 100) begin
      @(negedge clk);
      cycles++;
      busGrant = 1'b0;
      if (withSnoop && cycles == 1) begin
        snoopValid = 1'b0;
        check(cpuReady == 1'b0, "R10", "access completed in snoop cycle", cpuReady, 0);
      end
      if (cpuReady) begin
        done = 1;
        if (!wr) check(cpuRdata == golden[a], "R11", "load data", cpuRdata, golden[a]);
      end else if (busReq) begin
        if (!holding) begin
          holding = 1; hCmd = busCmd; hAddr = busAddr; waitLeft = int'($urandom % 3);
        end else begin
          check(busCmd == hCmd && busAddr == hAddr, "R12", "request changed before grant",
                {busCmd, busAddr}, {hCmd, hAddr});
        end
        if (waitLeft > 0) begin
          waitLeft--;
        end else begin
          holding = 0;
          busGrant = 1'b1;
          busFillData = mem[busAddr];
          if (expWb && !wbSeen) begin
            wbSeen = 1;
            check(busCmd == 2'd3, "R9", "writeback command", busCmd, 3);
            check(busAddr == vAddr, "R9", "writeback address", busAddr, vAddr);
            check(busWdata == vData, "R9", "writeback data", busWdata, vData);
            mem[busAddr] = busWdata;
          end else if (expFill && !fillSeen) begin
            fillSeen = 1;
            check(busCmd == expCmd, fillLbl, "fill command", busCmd, expCmd);
            check(busAddr == a, fillLbl, "fill address", busAddr, a);
          end else begin
            check(0, "R5", "unexpected bus transaction", busCmd, 0);
          end
        end
      end
    end
    cpuReq = 1'b0;
    busGrant = 1'b0;
    check(done, "R11", "completion", done, 1);
    check(wbSeen == expWb, "R9", "writeback count", wbSeen, expWb);
    check(fillSeen == expFill, fillLbl, "fill count", fillSeen, expFill);
    if (hit)
      check(cycles == (withSnoop ? 2 : 1), "R5", "hit latency", cycles, withSnoop ? 2 : 1);
    if (expWb) mState[idx] = 0;
    if (expFill) begin
      mTag[idx]   = tg;
      mState[idx] = wr ? 2 : 1;
      mData[idx]  = mem[a];
    end
    if (wr) begin
      mState[idx] = 2;
      mData[idx]  = wd;
      golden[a]   = wd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog R11: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = DATA_W'(i * 37 + 5);
      golden[i] = mem[i];
    end
    for (int i = 0; i < LINES; i++) begin
      mState[i] = 0; mTag[i] = '0; mData[i] = '0;
    end
    rstN = 1'b0; cpuReq = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0;
    busGrant = 1'b0; busFillData = '0;
    snoopValid = 1'b0; snoopExcl = 1'b0; snoopAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuReady == 0, "R1", "ready after reset", cpuReady, 0);
    check(busReq == 0, "R1", "bus request after reset", busReq, 0);
    check(snoopFlush == 0, "R1", "flush after reset", snoopFlush, 0);
    for (int i = 0; i < LINES; i++) snoopOnly(1'b0, ADDR_W'(i));

    // directed corner cases
    doOp(1'b1, 6'h01, 16'hBEEF, 0, 0, '0);   // R3 store miss
    doOp(1'b0, 6'h01, '0, 0, 0, '0);         // R5 load hit modified
    snoopOnly(1'b0, 6'h01);                  // R6 flush, demote
    doOp(1'b1, 6'h01, 16'h1234, 0, 0, '0);   // R4 upgrade
    snoopOnly(1'b1, 6'h01);                  // R7 flush, invalidate
    doOp(1'b0, 6'h01, '0, 0, 0, '0);         // R2 load miss
    snoopOnly(1'b0, 6'h01);                  // R8 stays shared
    doOp(1'b0, 6'h01, '0, 0, 0, '0);         // R5 load hit shared
    snoopOnly(1'b1, 6'h01);                  // R7 shared invalidate
    snoopOnly(1'b1, 6'h05);                  // R13 tag mismatch
    doOp(1'b1, 6'h02, 16'hA5A5, 0, 0, '0);
    doOp(1'b0, 6'h06, '0, 0, 0, '0);         // R9 dirty victim
    doOp(1'b0, 6'h02, '0, 0, 0, '0);         // R9 clean victim dropped
    doOp(1'b1, 6'h03, 16'h7777, 0, 0, '0);
    doOp(1'b1, 6'h03, 16'h8888, 1, 1'b0, 6'h03); // R10 demote then upgrade
    doOp(1'b0, 6'h03, '0, 1, 1'b1, 6'h03);   // R10 invalidate then miss
    doOp(1'b1, 6'h07, 16'h4242, 1, 1'b0, 6'h03);

    // seeded random traffic
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom % 10);
      logic [ADDR_W-1:0] a = ADDR_W'($urandom % 16);
      logic [ADDR_W-1:0] sa = ($urandom % 2 == 0) ? a : ADDR_W'($urandom % 16);
      if (r < 2) snoopOnly(1'($urandom % 2), sa);
      else doOp(1'($urandom % 2), a, DATA_W'($urandom), ($urandom % 5) == 0, 1'($urandom % 2), sa);
    end

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule